// File: doc/BRIEF.md
# Configurable Serial Peripheral Port (master or slave)

This block moves one byte at a time over a four-wire serial link. It can act as master or as slave. Software sets it up through an 8-bit control register. It reaches the block over a small CPU bus with a 2-bit address, a read strobe, a write strobe and a data word. As master, the port makes the serial clock from the system clock at one of four rates. As slave, it takes the serial clock and an active-low select from outside. In slave mode those inputs go through a two-flop synchronizer.

Clock polarity and clock phase give the four usual clock-data relationships. In phase-0 mode the link clock is gated by the select input. The transfer starts when select falls. If select rises part way through a byte, the transfer is abandoned. In phase-1 mode select only enables the slave data output.

A completion flag, together with an optional interrupt, reports the end of each byte. A collision flag reports a data write made while a byte is in flight. A single open-drain option changes every output pin of the port to pull-down-only behaviour. It does this through the output enables.

Register map (byte address): 0 = control, 1 = status, 2 = data.

Top module: `spi_port`

## Requirements
- R1: After reset, control bits 7..2 read 000001: the phase bit is 1 and the interrupt-enable (bit 7), system-enable (bit 6), open-drain (bit 5), master (bit 4) and polarity (bit 3) bits are 0. Rate bits 1..0 are unspecified. Status reads 0x00, the interrupt is low and no output enable is active.
- R2: In master mode, rate code 00, 01, 10 or 11 in control bits 1..0 gives a serial clock period of 2, 4, 16 or 32 system clocks.
- R3: When polarity (bit 3) is 0, an idle master holds the serial clock low. When it is 1, the idle master holds it high.
- R4: A data write in master mode with the system enabled starts a transfer. Data leaves MSB first. When phase (bit 2) is 0, each bit is stable at the leading clock edge. When phase is 1, each bit is stable at the trailing edge. The byte read back from the data register after completion is the byte sampled from the input line.
- R5: A phase-0 slave presents the MSB of its preloaded byte as soon as select falls, samples on leading edges and shifts out on trailing edges.
- R6: A phase-1 slave changes its output on each leading edge and samples on each trailing edge.
- R7: In phase-0 slave mode, select rising before the eighth bit abandons the byte. The completion flag stays clear and the bit counter returns to zero.
- R8: Status bit 7 sets when a byte completes. It clears only when a status read that saw it set is followed by a data-register read or write.
- R9: A data write while a byte is in flight sets status bit 6 and leaves the byte in flight unchanged. Status bit 6 clears by the same sequence as in R8.
- R10: The interrupt output is high only while both the completion flag and interrupt-enable (bit 7) are set.
- R11: With system-enable (bit 6) clear, a data write starts nothing, no output enable is active and no completion occurs.
- R12: With open-drain (bit 5) set, no output pin has its enable active while its value is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Master-to-slave data in (slave) |
| mosi_o | output | 1 | Master-to-slave data out (master) |
| mosi_oe_o | output | 1 | Enable for mosi_o |
| miso_i | input | 1 | Slave-to-master data in (master) |
| miso_o | output | 1 | Slave-to-master data out (slave) |
| miso_oe_o | output | 1 | Enable for miso_o |

## Verification
The hardest case to reach from the ports is the abandoned phase-0 slave byte. It needs select to rise after a few clock pulses and before the eighth. The bench drives the slave pins by hand and deasserts select after three pulses. It then checks that no completion was reported. Next it runs a full byte and shows that the received value is exact, which could not happen if the bit counter had kept its partial count. The collision case is reached by writing the data register a second time in the middle of a slow master transfer. In master mode the data input is looped back from the data output, so every received byte must equal the byte sent.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
    typedef struct packed {
        logic       irq_en;
        logic       sys_en;
        logic       od_en;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [7:0] CTRL_RST = 8'h04;
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
    parameter int           W    = 3,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= INIT;
            s2_q <= INIT;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/spi_rate_div.sv
`timescale 1ns/1ps
module spi_rate_div #(
    parameter int CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q, lim;

    // half period minus one, in system clocks
    always_comb begin
        case (rate)
            2'b00:   lim = CNT_W'(0);
            2'b01:   lim = CNT_W'(1);
            2'b10:   lim = CNT_W'(7);
            default: lim = CNT_W'(15);
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == lim) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    rate_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rate != 2'b00) |=> (!tick || rate == 2'b00));
endmodule

// File: rtl/spi_engine.sv
`timescale 1ns/1ps
module spi_engine #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sys_en,
    input  logic          master,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    input  logic          tick,
    input  logic          s_sck,
    input  logic          s_ss_n,
    input  logic          s_mosi,
    input  logic          m_miso,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rx_o,
    output logic          obit_o,
    output logic          sck_lvl_o
);
    localparam int BW = $clog2(DW);
    localparam logic [BW:0]   HALF_LAST = (BW+1)'(2*DW-1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(DW-1);

    typedef struct packed {
        logic [DW-1:0] sreg;
        logic [DW-1:0] rx;
        logic [BW-1:0] cnt;
        logic [BW:0]   half;
        logic          sck_lvl;
        logic          busy;
        logic          obit;
        logic          k_prev;
        logic          ss_prev;
        logic          done;
    } st_t;

    st_t d, q;
    logic k, lead, trail, smp, chg, din;

    assign k = s_sck ^ cpol;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.k_prev  = k;
        d.ss_prev = s_ss_n;
        lead      = 1'b0;
        trail     = 1'b0;
        if (master) begin
            if (q.busy && tick) begin
                lead  = !q.sck_lvl;
                trail = q.sck_lvl;
            end
        end else begin
            lead  = !s_ss_n && k && !q.k_prev;
            trail = !s_ss_n && !k && q.k_prev;
        end
        din = master ? m_miso : s_mosi;
        smp = cpha ? trail : lead;
        chg = cpha ? lead : trail;

        if (load) begin
            d.sreg = wdata;
            d.obit = wdata[DW-1];
            if (master && sys_en) begin
                d.busy    = 1'b1;
                d.half    = '0;
                d.cnt     = '0;
                d.sck_lvl = 1'b0;
            end
        end

        if (!sys_en) begin
            d.busy    = 1'b0;
            d.cnt     = '0;
            d.half    = '0;
            d.sck_lvl = 1'b0;
        end else begin
            if (master && q.busy && tick) begin
                d.sck_lvl = !q.sck_lvl;
                d.half    = q.half + 1'b1;
                if (q.half == HALF_LAST) begin
                    d.busy    = 1'b0;
                    d.sck_lvl = 1'b0;
                end
            end
            if (!master && !cpha) begin
                if (!s_ss_n && q.ss_prev && !load) d.obit = q.sreg[DW-1];
                if (s_ss_n && !q.ss_prev)          d.cnt  = '0;
            end
            if (chg) d.obit = q.sreg[DW-1];
            if (smp) begin
                d.sreg = {q.sreg[DW-2:0], din};
                if (q.cnt == BIT_LAST) begin
                    d.cnt  = '0;
                    d.done = 1'b1;
                    d.rx   = {q.sreg[DW-2:0], din};
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.k_prev  <= 1'b0;
            q.ss_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = q.busy || (q.cnt != '0);
    assign done_o    = q.done;
    assign rx_o      = q.rx;
    assign obit_o    = q.obit;
    assign sck_lvl_o = q.sck_lvl;

    // R11
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_en |=> !busy_o);
    // R3
    sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !q.busy) |-> !q.sck_lvl);
    // R7
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_en && !master && !cpha && s_ss_n && !q.ss_prev) |=> (q.cnt == '0));
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_W = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe_o,
    input  logic          ss_n_i,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe_o,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe_o
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  done;
        logic  wcol;
        logic  armed;
    } regs_t;

    regs_t d, q;
    logic [2:0]    s_pins;
    logic          eng_busy, eng_done, obit, sck_lvl, tick, load;
    logic          wr_data, rd_data, m_en, sck_val;
    logic [DW-1:0] rx;

    spi_sync #(.W(3), .INIT(3'b010)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({sck_i, ss_n_i, mosi_i}),
        .q   (s_pins)
    );

    spi_rate_div #(.CNT_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n (rst_n),
        .run  (m_en && eng_busy),
        .rate (q.ctrl.rate),
        .tick (tick)
    );

    spi_engine #(.DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_en    (q.ctrl.sys_en),
        .master    (q.ctrl.master),
        .cpol      (q.ctrl.cpol),
        .cpha      (q.ctrl.cpha),
        .load      (load),
        .wdata     (wdata_i),
        .tick      (tick),
        .s_sck     (s_pins[2]),
        .s_ss_n    (s_pins[1]),
        .s_mosi    (s_pins[0]),
        .m_miso    (miso_i),
        .busy_o    (eng_busy),
        .done_o    (eng_done),
        .rx_o      (rx),
        .obit_o    (obit),
        .sck_lvl_o (sck_lvl)
    );

    assign wr_data = wr_i && (addr_i == A_DATA);
    assign rd_data = rd_i && (addr_i == A_DATA);
    assign load    = wr_data && !eng_busy;

    always_comb begin
        d = q;
        if (wr_i && addr_i == A_CTRL) d.ctrl = ctrl_t'(wdata_i[7:0]);
        if (rd_i && addr_i == A_STAT && (q.done || q.wcol)) d.armed = 1'b1;
        if (q.armed && (rd_data || wr_data)) begin
            d.done  = 1'b0;
            d.wcol  = 1'b0;
            d.armed = 1'b0;
        end
        if (wr_data && eng_busy) d.wcol = 1'b1;
        if (eng_done)            d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ctrl <= ctrl_t'(CTRL_RST);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr_i)
            A_CTRL:  rdata_o = DW'(q.ctrl);
            A_STAT:  rdata_o = DW'({q.done, q.wcol, 6'b0});
            A_DATA:  rdata_o = rx;
            default: rdata_o = '0;
        endcase
    end

    assign irq_o   = q.ctrl.irq_en && q.done;
    assign m_en    = q.ctrl.sys_en && q.ctrl.master;
    assign sck_val = sck_lvl ^ q.ctrl.cpol;

    assign sck_o     = sck_val;
    assign mosi_o    = obit;
    assign miso_o    = obit;
    assign sck_oe_o  = m_en && !(q.ctrl.od_en && sck_val);
    assign mosi_oe_o = m_en && !(q.ctrl.od_en && obit);
    assign miso_oe_o = q.ctrl.sys_en && !q.ctrl.master && !ss_n_i
                       && !(q.ctrl.od_en && obit);

    // R8
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $past(eng_done));
    // R9
    wcol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wcol) |-> $past(wr_i && addr_i == A_DATA && eng_busy));
    // R12
    od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ctrl.od_en |-> !((sck_oe_o && sck_o) || (mosi_oe_o && mosi_o)
                           || (miso_oe_o && miso_o)));
endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
    import spi_port_pkg::*;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       irq_o, sck_o, sck_oe_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o, miso_i;
    logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;

    always #2.5 clk = ~clk;

    spi_port dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_o),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o), .ss_n_i(ss_n_i),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o)
    );

    assign miso_i = mosi_o;

    int    checks = 0, fails = 0;
    bit    finished = 1'b0;
    int    exp_q[$], got_q[$];
    string req_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0 && exp_q.size() > 0) begin
                int g, e;
                string r;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(g == e, r, g, e);
            end
        end
    end

    task automatic master_xfer(input logic cpol, input logic cpha, input logic [1:0] rate,
                               input logic [7:0] v);
        logic [7:0] bits, s, r;
        bus_wr(A_CTRL, {1'b1, 1'b1, 1'b0, 1'b1, cpol, cpha, rate});
        bus_wr(A_DATA, v);
        for (int i = 7; i >= 0; i--) begin
            if (cpol == cpha) @(posedge sck_o);
            else              @(negedge sck_o);
            bits[i] = mosi_o;
        end
        check(bits == v, "R4 mosi bits MSB first at sample edge", bits, v);
        wait (irq_o);
        bus_rd(A_STAT, s);
        check(s[7] == 1'b1, "R8 done flag set", s, 8'h80);
        bus_rd(A_DATA, r);
        got_q.push_back(r); exp_q.push_back(v); req_q.push_back("R4 loopback byte");
        repeat (40) @(negedge clk);
    endtask

    task automatic slave_xfer(input logic cpol, input logic cpha,
                              input logic [7:0] tx, input logic [7:0] rxv, input string req);
        logic [7:0] bits, s, r;
        @(negedge clk);
        sck_i = cpol; ss_n_i = 1'b1;
        bus_wr(A_CTRL, {1'b1, 1'b1, 1'b0, 1'b0, cpol, cpha, 2'b11});
        bus_wr(A_DATA, tx);
        repeat (4) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (H) @(negedge clk);
        check(miso_oe_o == 1'b1, {req, " miso enabled under select"}, miso_oe_o, 1);
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                mosi_i = rxv[i];
                bits[i] = miso_o;
                sck_i = ~cpol;
                repeat (H) @(negedge clk);
                sck_i = cpol;
                repeat (H) @(negedge clk);
            end else begin
                sck_i = ~cpol;
                mosi_i = rxv[i];
                repeat (H) @(negedge clk);
                bits[i] = miso_o;
                sck_i = cpol;
                repeat (H) @(negedge clk);
            end
        end
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check(bits == tx, {req, " miso bits MSB first"}, bits, tx);
        check(irq_o == 1'b1, {req, " completion irq"}, irq_o, 1);
        bus_rd(A_STAT, s);
        bus_rd(A_DATA, r);
        got_q.push_back(r); exp_q.push_back(rxv); req_q.push_back({req, " received byte"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, r;
        realtime t0, t1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(A_CTRL, r);
        check((r & 8'hFC) == 8'h04, "R1 control reset", r & 8'hFC, 8'h04);
        bus_rd(A_STAT, s);
        check(s == 8'h00, "R1 status reset", s, 0);
        check({irq_o, sck_oe_o, mosi_oe_o, miso_oe_o} == 4'b0, "R1 irq and enables low",
              {irq_o, sck_oe_o, mosi_oe_o, miso_oe_o}, 0);

        // R11 disabled: nothing starts
        bus_wr(A_CTRL, 8'b1001_0000);
        bus_wr(A_DATA, 8'h5A);
        repeat (100) @(negedge clk);
        check(irq_o == 1'b0 && sck_oe_o == 1'b0, "R11 no activity when disabled",
              {irq_o, sck_oe_o}, 0);
        bus_rd(A_STAT, s);
        check(s == 8'h00, "R11 no completion when disabled", s, 0);

        // R3 idle polarity
        bus_wr(A_CTRL, 8'b0101_0000);
        check(sck_o == 1'b0 && sck_oe_o == 1'b1, "R3 idle low with polarity 0", sck_o, 0);
        bus_wr(A_CTRL, 8'b0101_1000);
        check(sck_o == 1'b1 && sck_oe_o == 1'b1, "R3 idle high with polarity 1", sck_o, 1);

        // R2 rates
        for (int c = 0; c < 4; c++) begin
            int per, expp;
            expp = (c == 0) ? 2 : (c == 1) ? 4 : (c == 2) ? 16 : 32;
            bus_wr(A_CTRL, {6'b0101_00, 2'(c)});
            bus_wr(A_DATA, 8'h00);
            @(posedge sck_o); t0 = $realtime;
            @(posedge sck_o); t1 = $realtime;
            per = int'((t1 - t0) / 5.0);
            check(per == expp, "R2 master clock period", per, expp);
            repeat (400) @(negedge clk);
            bus_rd(A_STAT, s);
            bus_rd(A_DATA, r);
        end

        // R4 four clock modes, master loopback
        master_xfer(1'b0, 1'b0, 2'b01, 8'hA5);
        master_xfer(1'b0, 1'b1, 2'b00, 8'h3C);
        master_xfer(1'b1, 1'b0, 2'b10, 8'h81);
        master_xfer(1'b1, 1'b1, 2'b01, 8'h5E);

        // R8 data access alone does not clear
        bus_wr(A_CTRL, 8'b1101_0100);
        bus_wr(A_DATA, 8'h42);
        wait (irq_o);
        bus_rd(A_DATA, r);
        check(irq_o == 1'b1, "R8 data read without status read keeps flag", irq_o, 1);
        bus_rd(A_STAT, s);
        bus_rd(A_DATA, r);
        check(irq_o == 1'b0, "R8 flag cleared by status then data", irq_o, 0);
        bus_rd(A_STAT, s);
        check(s == 8'h00, "R8 status clear", s, 0);

        // R10 interrupt gating
        bus_wr(A_CTRL, 8'b0101_0000);
        bus_wr(A_DATA, 8'h77);
        repeat (60) @(negedge clk);
        check(irq_o == 1'b0, "R10 irq low with enable clear", irq_o, 0);
        bus_rd(A_STAT, s);
        check(s[7] == 1'b1, "R10 done set without irq", s, 8'h80);
        bus_wr(A_CTRL, 8'b1101_0000);
        check(irq_o == 1'b1, "R10 irq follows enable", irq_o, 1);
        bus_rd(A_DATA, r);
        check(irq_o == 1'b0 && r == 8'h77, "R10 irq drops after clear", r, 8'h77);

        // R9 write collision
        bus_wr(A_CTRL, 8'b1101_0011);
        bus_wr(A_DATA, 8'h96);
        repeat (20) @(negedge clk);
        bus_wr(A_DATA, 8'h11);
        wait (irq_o);
        repeat (40) @(negedge clk);
        bus_rd(A_STAT, s);
        check(s == 8'hC0, "R9 collision and done flags", s, 8'hC0);
        bus_rd(A_DATA, r);
        check(r == 8'h96, "R9 byte in flight undisturbed", r, 8'h96);
        bus_rd(A_STAT, s);
        check(s == 8'h00, "R9 collision flag cleared", s, 0);

        // R12 open drain
        bus_wr(A_CTRL, 8'b0111_1000);
        check(sck_oe_o == 1'b0, "R12 high level not driven", sck_oe_o, 0);
        bus_wr(A_CTRL, 8'b0111_0000);
        check(sck_oe_o == 1'b1 && sck_o == 1'b0, "R12 low level driven", sck_oe_o, 1);
        bus_wr(A_CTRL, 8'b0101_1000);
        check(sck_oe_o == 1'b1 && sck_o == 1'b1, "R12 push-pull drives high", sck_oe_o, 1);

        // R5 and R6 slave modes
        slave_xfer(1'b0, 1'b0, 8'hC3, 8'h5A, "R5");
        slave_xfer(1'b1, 1'b1, 8'h2D, 8'hB4, "R6");

        // R7 abort under phase 0
        @(negedge clk);
        sck_i = 1'b0;
        bus_wr(A_CTRL, 8'b1100_0000);
        bus_wr(A_DATA, 8'hF0);
        repeat (4) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            mosi_i = 1'b1;
            sck_i = 1'b1;
            repeat (H) @(negedge clk);
            sck_i = 1'b0;
            repeat (H) @(negedge clk);
        end
        ss_n_i = 1'b1;
        repeat (8) @(negedge clk);
        check(irq_o == 1'b0, "R7 no completion after abort", irq_o, 0);
        bus_rd(A_STAT, s);
        check(s == 8'h00, "R7 status clear after abort", s, 0);
        slave_xfer(1'b0, 1'b0, 8'h0F, 8'h69, "R7 after abort");

        repeat (10) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule